// File: doc/BRIEF.md
# Synchronous Bus Master Transaction Engine

This block is the master side of a synchronous shared system bus. The bus has a 24-bit byte address, giving a 16 MB space, and a 32-bit data path. A local requester, such as a load/store unit, hands over one read or write at a time through a valid/ready handshake. The engine then puts the transfer on the bus just after a rising clock edge. It holds every line steady cycle after cycle until the addressed slave raises acknowledge. When acknowledge arrives, it releases the bus and reports completion to the requester with a one-cycle done pulse. On a read, it also returns the captured data.

Transfers have no fixed length. A transfer lasts exactly as many cycles as the slave takes to acknowledge. A byte qualifier line marks single-byte writes, which may go to unaligned addresses. The tri-state enables for the shared lines are gated by an external grant input, so that a second master can take over the wires. The bus reset is asynchronous and wipes out any transfer in flight at once.

Top module: `sbus_master`

## Requirements
- R1: While `bus_rst` is high, and from the moment it rises without waiting for a clock, `sync_o`, `wr_o`, `byte_o`, `addr_o`, `data_o` and `done` are all zero. After release, `req_ready` is 1.
- R2: When a write is accepted (`req_valid`=1, `req_write`=1 and `req_ready`=1 at a rising edge), the next cycle shows `sync_o`=1, `wr_o`=1, `addr_o`=`req_addr` and `data_o`=`req_wdata`.
- R3: When a read is accepted (`req_write`=0), the next cycle shows `sync_o`=1, `wr_o`=0, `addr_o`=`req_addr`, and `data_oe`=0.
- R4: While a transfer is active and `ack_i` is sampled low at a rising edge, `sync_o`, `wr_o`, `byte_o`, `addr_o` and `data_o` keep their values through the next cycle.
- R5: A rising edge with a transfer active and `ack_i`=1 ends the transfer. In the following cycle, `sync_o`, `wr_o`, `byte_o`, `addr_o` and `data_o` are 0, and `done` is 1 for exactly that one cycle.
- R6: For a read, `rdata` equals the value of `data_i` sampled at the acknowledging edge, and it is valid while `done`=1.
- R7: `byte_o` is 1 only during a write accepted with `req_byte`=1. It stays 0 for word writes and for reads whatever `req_byte` is.
- R8: `req_ready` is 0 from the accepting edge until the completing edge. A `req_valid` presented in that window is ignored, and the bus lines do not change.
- R9: When `bus_grant` is 0, all five enables are 0. When it is 1, `sync_oe` is 1. `addr_oe`, `wr_oe` and `byte_oe` are 1 only while a transfer is active. `data_oe` is 1 only while a write is active.
- R10: While no transfer is active, `sync_o` is 0, so a granted but idle master drives the strobe inactive.
- R11: `ack_i` seen while no transfer is active has no effect: `done` stays 0 and `req_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; rising edge samples and launches |
| bus_rst | input | 1 | Asynchronous bus reset, active high |
| req_valid | input | 1 | Requester has a transfer to issue |
| req_ready | output | 1 | Engine can accept a transfer |
| req_write | input | 1 | 1 for write, 0 for read |
| req_byte | input | 1 | Single-byte write qualifier |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 32 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Data captured on a read |
| bus_grant | input | 1 | External grant gating all tri-state enables |
| ack_i | input | 1 | Slave acknowledge |
| data_i | input | 32 | Data bus as received |
| addr_o | output | 24 | Address bus value |
| addr_oe | output | 1 | Address bus enable |
| data_o | output | 32 | Data bus value driven on writes |
| data_oe | output | 1 | Data bus enable |
| sync_o | output | 1 | Transfer strobe |
| sync_oe | output | 1 | Strobe enable |
| wr_o | output | 1 | Direction line, 1 for write |
| wr_oe | output | 1 | Direction line enable |
| byte_o | output | 1 | Byte-write qualifier line |
| byte_oe | output | 1 | Byte line enable |

## Verification
The only state inside the engine is the active flag and the latched transfer fields. If the active flag is wrong, it shows within one cycle as a strobe that fails to rise, fails to drop, or drops without acknowledge. It also shows as `req_ready` disagreeing with `sync_o`. A corrupted latched field shows on `addr_o`, `data_o`, `wr_o` or `byte_o` in the first cycle of the transfer, and it persists through every hold cycle. A wrong capture shows in `rdata` during the single `done` cycle.

// File: rtl/sbus_master.sv
module sbus_master #(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          bus_rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_byte,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  input  logic          bus_grant,
  input  logic          ack_i,
  input  logic [DW-1:0] data_i,
  output logic [AW-1:0] addr_o,
  output logic          addr_oe,
  output logic [DW-1:0] data_o,
  output logic          data_oe,
  output logic          sync_o,
  output logic          sync_oe,
  output logic          wr_o,
  output logic          wr_oe,
  output logic          byte_o,
  output logic          byte_oe
);

  logic          busy, wr_q, byte_q, done_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q, rdata_q;

  always_ff @(posedge clk or posedge bus_rst) begin
    if (bus_rst) begin
      busy    <= 1'b0;
      wr_q    <= 1'b0;
      byte_q  <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy   <= 1'b1;
          wr_q   <= req_write;
          byte_q <= req_write & req_byte;
          addr_q <= req_addr;
          data_q <= req_write ? req_wdata : '0;
        end
      end else if (ack_i) begin
        busy   <= 1'b0;
        done_q <= 1'b1;
        if (!wr_q) rdata_q <= data_i;
        wr_q   <= 1'b0;
        byte_q <= 1'b0;
        addr_q <= '0;
        data_q <= '0;
      end
    end
  end

  assign req_ready = !busy;
  assign done      = done_q;
  assign rdata     = rdata_q;

  assign sync_o  = busy;
  assign wr_o    = wr_q;
  assign byte_o  = byte_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;

  assign sync_oe = bus_grant;
  assign addr_oe = bus_grant & busy;
  assign wr_oe   = bus_grant & busy;
  assign byte_oe = bus_grant & busy;
  assign data_oe = bus_grant & busy & wr_q;

endmodule

// File: rtl/sbus_master_chk.sv
module sbus_master_chk #(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          bus_rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic [DW-1:0] rdata,
  input logic          bus_grant,
  input logic          ack_i,
  input logic [DW-1:0] data_i,
  input logic [AW-1:0] addr_o,
  input logic          addr_oe,
  input logic [DW-1:0] data_o,
  input logic          data_oe,
  input logic          sync_o,
  input logic          sync_oe,
  input logic          wr_o,
  input logic          wr_oe,
  input logic          byte_o,
  input logic          byte_oe
);

  p_hold_r4: assert property (@(posedge clk) disable iff (bus_rst)
    sync_o && !ack_i |=> sync_o && $stable(addr_o) && $stable(data_o)
                         && $stable(wr_o) && $stable(byte_o));

  p_release_r5: assert property (@(posedge clk) disable iff (bus_rst)
    sync_o && ack_i |=> !sync_o && !wr_o && !byte_o && done);

  p_pulse_r5: assert property (@(posedge clk) disable iff (bus_rst)
    done |=> !done);

  p_capture_r6: assert property (@(posedge clk) disable iff (bus_rst)
    sync_o && ack_i && !wr_o |=> rdata == $past(data_i));

  p_byte_r7: assert property (@(posedge clk) disable iff (bus_rst)
    byte_o |-> wr_o && sync_o);

  p_busy_r8: assert property (@(posedge clk) disable iff (bus_rst)
    sync_o |-> !req_ready);

  p_oe_r9: assert property (@(posedge clk) disable iff (bus_rst)
    !bus_grant |-> !(addr_oe || data_oe || sync_oe || wr_oe || byte_oe));

  p_dataoe_r9: assert property (@(posedge clk) disable iff (bus_rst)
    data_oe |-> wr_o && bus_grant);

  p_idle_ack_r11: assert property (@(posedge clk) disable iff (bus_rst)
    !sync_o && ack_i |=> !done);

endmodule

bind sbus_master sbus_master_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/test_sbus_master.sv
module test_sbus_master;
  logic        clk = 1'b0;
  logic        bus_rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        bus_grant = 1'b0, ack_i = 1'b0;
  logic [31:0] data_i = '0;
  logic        req_ready, done;
  logic [31:0] rdata;
  logic [23:0] addr_o;
  logic [31:0] data_o;
  logic        addr_oe, data_oe, sync_o, sync_oe, wr_o, wr_oe, byte_o, byte_oe;

  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sbus_master i_sbus_master (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_byte(logic w, logic b);
    return w & b;
  endfunction

  function automatic logic exp_doe(logic g, logic w);
    return g & w;
  endfunction

  task automatic run_txn(logic w, logic b, logic [23:0] a, logic [31:0] wd,
                         logic g, int waits, logic [31:0] rd);
    @(negedge clk);
    bus_grant = g;
    req_valid = 1'b1; req_write = w; req_byte = b; req_addr = a; req_wdata = wd;
    chk("R8 ready idle", req_ready, 1);
    chk("R10 sync idle", sync_o, 0);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2/R3 sync", sync_o, 1);
    chk("R2/R3 addr", addr_o, a);
    chk("R2/R3 wr", wr_o, w);
    if (w) chk("R2 data", data_o, wd);
    chk("R7 byte", byte_o, exp_byte(w, b));
    chk("R9 data_oe", data_oe, exp_doe(g, w));
    chk("R9 addr_oe", addr_oe, g);
    chk("R9 sync_oe", sync_oe, g);
    chk("R8 ready busy", req_ready, 0);
    for (int k = 0; k < waits; k++) begin
      req_valid = 1'b1; req_write = ~w; req_addr = ~a; req_wdata = ~wd;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R4 hold sync", sync_o, 1);
      chk("R4 hold addr", addr_o, a);
      chk("R4 hold wr", wr_o, w);
      chk("R8 ignored", req_ready, 0);
    end
    ack_i = 1'b1; data_i = rd;
    @(posedge clk);
    @(negedge clk);
    ack_i = 1'b0; data_i = $urandom;
    chk("R5 done", done, 1);
    chk("R5 sync off", sync_o, 0);
    chk("R5 addr off", addr_o, 0);
    chk("R5 wr off", wr_o, 0);
    chk("R5 byte off", byte_o, 0);
    if (!w) chk("R6 rdata", rdata, rd);
    @(posedge clk);
    @(negedge clk);
    chk("R5 pulse", done, 0);
  endtask

  initial begin
    void'($urandom(32'd17));
    #1;
    chk("R1 reset sync", sync_o, 0);
    chk("R1 reset done", done, 0);
    @(negedge clk); @(negedge clk);
    bus_rst = 1'b0;
    chk("R1 ready", req_ready, 1);
    chk("R1 addr", addr_o, 0);
    // directed
    run_txn(1, 0, 24'hFFFFFC, 32'hDEADBEEF, 1, 0, 0);
    run_txn(0, 1, 24'h000003, 32'h0, 1, 2, 32'hA5A5_5A5A);
    run_txn(1, 1, 24'h123457, 32'h0000_00C3, 1, 3, 0);
    run_txn(1, 0, 24'h000010, 32'h1111_2222, 0, 1, 0);
    // R11 idle ack
    @(negedge clk);
    ack_i = 1'b1;
    @(posedge clk); @(negedge clk);
    ack_i = 1'b0;
    chk("R11 no done", done, 0);
    chk("R11 ready", req_ready, 1);
    // random
    for (int n = 0; n < 60; n++)
      run_txn($urandom % 2, $urandom % 2, $urandom, $urandom, $urandom % 2,
              $urandom % 5, $urandom);
    // R1 asynchronous abort mid-transfer
    @(negedge clk);
    bus_grant = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_byte = 1'b1;
    req_addr = 24'hABCDEF; req_wdata = 32'h77;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk("R1 pre busy", sync_o, 1);
    #2 bus_rst = 1'b1;
    #1;
    chk("R1 async sync", sync_o, 0);
    chk("R1 async addr", addr_o, 0);
    chk("R1 async byte", byte_o, 0);
    chk("R1 async data", data_o, 0);
    @(negedge clk);
    bus_rst = 1'b0;
    chk("R1 ready after", req_ready, 1);
    run_txn(0, 0, 24'h000004, 0, 1, 1, 32'h0BAD_F00D);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule